// File: doc/BRIEF.md
# Processor Status Word Register with Guarded Trace Flag

This block holds a processor's status word: condition codes, a trace flag, a three-bit interrupt priority and mode bits. It takes five update sources: a console start pulse, a trap or interrupt load of a vector word, a return load of a stacked word, an explicit write from the bus or an instruction, and a set-priority operation. It picks at most one of them per cycle and registers the result. The trace flag is shielded from explicit writes. Only start, a trap load or a return load can change it, so a program cannot start or stop its own single-stepping.

A set-priority operation rewrites only the priority field. It also raises an inhibit flag, which the interrupt and trace logic use to hold off every interrupt and the trace trap until the next instruction has completed. Instruction decode and the trap sequencer sit outside the block and drive its strobes.

Top module: `psw_reg`

## Requirements
- R1: After reset the status word reads 0x0000 and the inhibit flag reads 0.
- R2: An applied explicit write loads every bit of the word from the write data except bit 4 (mask 0x0010, the trace flag), which keeps its previous value.
- R3: A start pulse clears the whole word, trace flag included, and clears the inhibit flag.
- R4: An applied trap load copies the whole trap word, bit 4 included, into the status word.
- R5: An applied return load copies the whole stacked word, bit 4 included, into the status word.
- R6: When several sources are active in one cycle, only the highest applies, in the order start, trap load, return load, explicit write, set-priority. All lower sources are ignored that cycle.
- R7: An applied set-priority operation writes the level into bits 7:5 and leaves every other bit unchanged.
- R8: The inhibit flag is set in the cycle after an applied set-priority operation. A set-priority request that a higher source overrides does not set it.
- R9: While set, the inhibit flag clears after the first instruction-done strobe that comes after the set-priority cycle. A done strobe in the same cycle as the set-priority operation does not clear it.
- R10: Every update shows on the outputs one clock after the cycle in which its strobe is sampled. With no source active, the word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Console start pulse |
| trap_ld_i | input | 1 | Trap or interrupt vector load strobe |
| trap_word_i | input | 16 | Status word fetched from the vector |
| rtn_ld_i | input | 1 | Return-from-interrupt or return-from-trace load strobe |
| rtn_word_i | input | 16 | Status word popped from the stack |
| wr_en_i | input | 1 | Explicit write strobe |
| wr_data_i | input | 16 | Explicit write data |
| spl_i | input | 1 | Set-priority strobe |
| spl_level_i | input | 3 | New priority level |
| instr_done_i | input | 1 | Instruction completion strobe |
| psw_o | output | 16 | Current status word |
| irq_inhibit_o | output | 1 | Interrupt and trace trap inhibit |

## Verification
The bench sets the trace flag through a trap load and then writes zeros to it, and it also writes ones into bit 4 while the flag is clear. A design that let explicit writes reach bit 4 would turn single-stepping on or off there. Colliding strobes in every pairing show whether a lower source leaks through or a lost set-priority request still raises the inhibit flag. Done strobes in the same cycle as the set-priority operation and in later cycles catch an inhibit flag that drops too early, which would let an interrupt slip in right after the priority change, or one that never drops and so stalls interrupts. A long random run of mixed strobes is compared cycle by cycle against a behavioural model.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W     = 16;
  localparam int TRACE_POS = 4;
  localparam int PRI_LSB   = 5;
  localparam int PRI_W     = 3;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_START = 3'd1,
    SRC_TRAP  = 3'd2,
    SRC_RTN   = 3'd3,
    SRC_WR    = 3'd4,
    SRC_SPL   = 3'd5
  } psw_src_e;
endpackage

// File: rtl/psw_rst_sync.sv
module psw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/psw_src_arb.sv
module psw_src_arb
  import psw_pkg::*;
(
  input  logic     start_i,
  input  logic     trap_ld_i,
  input  logic     rtn_ld_i,
  input  logic     wr_en_i,
  input  logic     spl_i,
  output psw_src_e src_o
);
  always_comb begin
    if (start_i)        src_o = SRC_START;
    else if (trap_ld_i) src_o = SRC_TRAP;
    else if (rtn_ld_i)  src_o = SRC_RTN;
    else if (wr_en_i)   src_o = SRC_WR;
    else if (spl_i)     src_o = SRC_SPL;
    else                src_o = SRC_NONE;
  end
endmodule

// File: rtl/psw_inhibit.sv
module psw_inhibit (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic set_i,
  input  logic done_i,
  output logic inhibit_o
);
  logic inh_q, inh_d, inh_en;

  always_comb begin
    inh_en = clr_i | set_i | (done_i & inh_q);
    if (clr_i)      inh_d = 1'b0;
    else if (set_i) inh_d = 1'b1;
    else            inh_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      inh_q <= 1'b0;
    else if (inh_en) inh_q <= inh_d;
  end

  assign inhibit_o = inh_q;

  // R9
  inh_done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q && done_i && !set_i && !clr_i) |=> !inh_q);
endmodule

// File: rtl/psw_reg.sv
module psw_reg
  import psw_pkg::*;
#(
  parameter int W           = PSW_W,
  parameter int TRACE_BIT   = TRACE_POS,
  parameter int LVL_LSB     = PRI_LSB,
  parameter int LVL_W       = PRI_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             trap_ld_i,
  input  logic [W-1:0]     trap_word_i,
  input  logic             rtn_ld_i,
  input  logic [W-1:0]     rtn_word_i,
  input  logic             wr_en_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             spl_i,
  input  logic [LVL_W-1:0] spl_level_i,
  input  logic             instr_done_i,
  output logic [W-1:0]     psw_o,
  output logic             irq_inhibit_o
);
  localparam int LVL_MSB = LVL_LSB + LVL_W - 1;

  logic         rst_n_s;
  psw_src_e     src;
  logic [W-1:0] psw_q, psw_d;
  logic         psw_en;

  psw_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s));

  psw_src_arb u_arb (
    .start_i(start_i), .trap_ld_i(trap_ld_i), .rtn_ld_i(rtn_ld_i),
    .wr_en_i(wr_en_i), .spl_i(spl_i), .src_o(src));

  always_comb begin
    psw_d  = psw_q;
    psw_en = (src != SRC_NONE);
    case (src)
      SRC_START: psw_d = '0;
      SRC_TRAP:  psw_d = trap_word_i;
      SRC_RTN:   psw_d = rtn_word_i;
      SRC_WR: begin
        psw_d            = wr_data_i;
        psw_d[TRACE_BIT] = psw_q[TRACE_BIT];
      end
      SRC_SPL:   psw_d[LVL_MSB:LVL_LSB] = spl_level_i;
      default:   psw_d = psw_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    psw_q <= '0;
    else if (psw_en) psw_q <= psw_d;
  end

  psw_inhibit u_inh (
    .clk(clk), .rst_n(rst_n_s),
    .clr_i(src == SRC_START), .set_i(src == SRC_SPL),
    .done_i(instr_done_i), .inhibit_o(irq_inhibit_o));

  assign psw_o = psw_q;

  // R2
  trace_guard_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en_i && !start_i && !trap_ld_i && !rtn_ld_i) |=> psw_o[TRACE_BIT] == $past(psw_o[TRACE_BIT]));
  // R3
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    start_i |=> (psw_o == '0) && !irq_inhibit_o);
  // R4
  trap_load_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (trap_ld_i && !start_i) |=> psw_o == $past(trap_word_i));
  // R5
  rtn_load_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rtn_ld_i && !start_i && !trap_ld_i) |=> psw_o == $past(rtn_word_i));
  // R7
  spl_level_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (spl_i && !start_i && !trap_ld_i && !rtn_ld_i && !wr_en_i)
      |=> psw_o[LVL_MSB:LVL_LSB] == $past(spl_level_i));
  // R8
  spl_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (spl_i && !start_i && !trap_ld_i && !rtn_ld_i && !wr_en_i) |=> irq_inhibit_o);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!spl_i && !start_i && !trap_ld_i && !rtn_ld_i && !wr_en_i) |=> $stable(psw_o));
endmodule

// File: tb/psw_reg_tb.sv
module psw_reg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, trap_ld_i, rtn_ld_i, wr_en_i, spl_i, instr_done_i;
  logic [15:0] trap_word_i, rtn_word_i, wr_data_i;
  logic [2:0]  spl_level_i;
  logic [15:0] psw_o;
  logic        irq_inhibit_o;

  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;
  string cur_req = "R1";

  int    m_psw;
  bit    m_inh;

  always #(CLK_PERIOD/2) clk = ~clk;

  psw_reg dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .trap_ld_i(trap_ld_i), .trap_word_i(trap_word_i),
    .rtn_ld_i(rtn_ld_i), .rtn_word_i(rtn_word_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .spl_i(spl_i), .spl_level_i(spl_level_i),
    .instr_done_i(instr_done_i),
    .psw_o(psw_o), .irq_inhibit_o(irq_inhibit_o));

  // Behavioural reference built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_psw = 0;
      m_inh = 0;
    end else begin
      if (start_i) begin
        m_psw = 0; m_inh = 0;
      end else if (trap_ld_i) begin
        m_psw = trap_word_i;
        if (instr_done_i) m_inh = 0;
      end else if (rtn_ld_i) begin
        m_psw = rtn_word_i;
        if (instr_done_i) m_inh = 0;
      end else if (wr_en_i) begin
        m_psw = (wr_data_i & 16'hFFEF) | (m_psw & 16'h0010);
        if (instr_done_i) m_inh = 0;
      end else if (spl_i) begin
        m_psw = (m_psw & 16'hFF1F) | (int'(spl_level_i) << 5);
        m_inh = 1;
      end else if (instr_done_i) begin
        m_inh = 0;
      end
    end
  end

  task automatic compare();
    checks++;
    if (psw_o !== m_psw[15:0] || irq_inhibit_o !== m_inh) begin
      failures++;
      $display("FAIL %s: psw=%h inh=%b expected psw=%h inh=%b at %0t",
               cur_req, psw_o, irq_inhibit_o, m_psw[15:0], m_inh, $time);
    end
  endtask

  task automatic clear_in();
    start_i = 0; trap_ld_i = 0; rtn_ld_i = 0; wr_en_i = 0; spl_i = 0;
    instr_done_i = 0; trap_word_i = 0; rtn_word_i = 0; wr_data_i = 0;
    spl_level_i = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    clear_in();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1;
    idle(5);

    // R2: ones written into bit 4 while trace clear are ignored
    cur_req = "R2"; wr_en_i = 1; wr_data_i = 16'h30FF; tick(); idle(1);
    // R4: trap load sets trace
    cur_req = "R4"; trap_ld_i = 1; trap_word_i = 16'hC0F3; tick(); idle(1);
    // R2: zeros written cannot clear trace
    cur_req = "R2"; wr_en_i = 1; wr_data_i = 16'h0000; tick(); idle(1);
    // R5: return load clears trace
    cur_req = "R5"; rtn_ld_i = 1; rtn_word_i = 16'h5A0F; tick();
    cur_req = "R5"; rtn_ld_i = 1; rtn_word_i = 16'h0015; tick();
    cur_req = "R2"; wr_en_i = 1; wr_data_i = 16'hFFEF; tick(); idle(1);
    // R7: priority only
    cur_req = "R7"; spl_i = 1; spl_level_i = 3'd2; tick();
    // R9: done in set cycle does not clear, next one does
    cur_req = "R9"; spl_i = 1; spl_level_i = 3'd5; instr_done_i = 1; tick();
    idle(2);
    cur_req = "R9"; instr_done_i = 1; tick(); idle(1);
    // R8: inhibit set
    cur_req = "R8"; spl_i = 1; spl_level_i = 3'd7; tick(); idle(1);
    // R3: start clears trace and inhibit
    cur_req = "R3"; trap_ld_i = 1; trap_word_i = 16'hFFFF; tick();
    cur_req = "R3"; spl_i = 1; tick();
    cur_req = "R3"; start_i = 1; tick(); idle(1);
    // R6: collisions
    cur_req = "R6"; start_i = 1; trap_ld_i = 1; trap_word_i = 16'h1234; tick();
    cur_req = "R6"; trap_ld_i = 1; trap_word_i = 16'h0030; rtn_ld_i = 1;
    rtn_word_i = 16'hAAAA; wr_en_i = 1; wr_data_i = 16'h5555; tick();
    cur_req = "R6"; rtn_ld_i = 1; rtn_word_i = 16'h0F00; wr_en_i = 1;
    wr_data_i = 16'hFFFF; tick();
    cur_req = "R8"; wr_en_i = 1; wr_data_i = 16'h00E0; spl_i = 1;
    spl_level_i = 3'd1; tick();
    // R10: hold with nothing active
    cur_req = "R10"; idle(4);

    cur_req = "R6";
    for (int i = 0; i < 400; i++) begin
      start_i      = ($urandom_range(0, 15) == 0);
      trap_ld_i    = ($urandom_range(0, 5) == 0);
      rtn_ld_i     = ($urandom_range(0, 4) == 0);
      wr_en_i      = ($urandom_range(0, 3) == 0);
      spl_i        = ($urandom_range(0, 3) == 0);
      instr_done_i = ($urandom_range(0, 2) == 0);
      trap_word_i  = 16'($urandom);
      rtn_word_i   = 16'($urandom);
      wr_data_i    = 16'($urandom);
      spl_level_i  = 3'($urandom);
      tick();
    end
    idle(2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule